// File: doc/BRIEF.md
# Channel Sync Hold-Off Controller

This block controls when one receive channel of a digital down-converter wakes and when its NCO changes frequency. A register port programs it. Two kinds of sync event exist. A software event comes from a write to a trigger register. A hardware event comes from an external sync pin, and that pin must pass both an enable stage and a select stage before it counts as an event. Each event kind drives a 16-bit hold-off counter, one for start and one for frequency hop. A programmed hold-off of 0 turns that action off. When a counter reaches 1, the action happens. For start, the channel leaves sleep and a start pulse is issued. For hop, the staged 32-bit frequency word is moved into the active frequency output in a single cycle, together with an update strobe.

The pin configuration of the channel holds a start enable, a hop enable and a first-pulse-only mode. It follows a global configuration input until the channel writes its own value. In first-pulse-only mode, only the first qualified pin pulse acts. Writing the pin configuration register arms the mode again.

Top module: `chan_sync_ctrl`

Register map (write-only, `wr_addr`): 0 trigger (bit0 start, bit1 hop); 1 pin config (bit0 start enable, bit1 hop enable, bit2 first-pulse-only); 2 pin select (bit0 pin drives start, bit1 pin drives hop); 3 start hold-off; 4 hop hold-off; 5 staged frequency low half; 6 staged frequency high half.

## Requirements
- R1: After reset, `sleep` is 1, `start_pulse` and `freq_upd` are 0, and `freq_word` is 0.
- R2: A write of 1 to bit0 of register 0 with start hold-off N>0 raises `start_pulse` for exactly one cycle, N clock edges after the write edge. `sleep` goes to 0 on that same edge and stays 0.
- R3: A write of 1 to bit1 of register 0 with hop hold-off N>0 raises `freq_upd` N edges after the write edge. On that edge `freq_word` takes {reg6, reg5}.
- R4: When the hold-off value is 0, a trigger of that kind causes no pulse, leaves `sleep` unchanged and leaves `freq_word` unchanged.
- R5: A second trigger that arrives while a counter is running reloads that counter. Only one pulse follows, N edges after the second trigger.
- R6: A pin pulse has no effect unless both its enable bit (register 1) and its select bit (register 2) are set for that action.
- R7: An enabled and selected rising edge on `sync_pin` acts like a trigger, with a latency of N+2 edges counted from the edge that first samples the pin high.
- R8: With the first-pulse-only bit set, only the first qualified pin pulse acts. A write to register 1 arms the mode again.
- R9: Until register 1 is written, the pin configuration follows `glb_pin_cfg`. After the write, the channel's own value is used.
- R10: `freq_word` changes only on a cycle where `freq_upd` is 1. Writes to the staged halves do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| sync_pin | input | 1 | External sync pin, asynchronous |
| glb_pin_cfg | input | 3 | Global pin configuration shared by all channels |
| start_pulse | output | 1 | One-cycle pulse when the channel starts |
| sleep | output | 1 | Channel sleep flag |
| freq_word | output | 32 | Active NCO frequency word |
| freq_upd | output | 1 | One-cycle strobe when `freq_word` is updated |

## Verification
A table of software triggers with several hold-off values runs first. The table includes the boundary value 1 and several larger values, so a counter that fires at 0 or that is off by one edge shows up as a wrong cycle count. Hop entries use distinct high and low patterns, so swapped or stale halves are caught. Directed pin sequences then step through every combination of enable, select, global configuration versus the channel's own configuration, and first-pulse-only with re-arming. Each step produces a different expected outcome, a pulse at N+2 or silence, so each gating stage is tested separately. A zero hold-off, a retrigger while counting, and staging writes without a hop complete the corner cases.

// File: rtl/chan_sync_pkg.sv
package chan_sync_pkg;
  parameter int DATA_W = 16;
  parameter int ADDR_W = 3;
  localparam int FREQ_W = 2 * DATA_W;
  localparam int CFG_W  = 3;

  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PCFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PSEL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STHO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_HPHO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLO   = 3'd5;
  localparam logic [ADDR_W-1:0] A_FHI   = 3'd6;

  // action index: bit 0 start, bit 1 hop
  localparam int ACT_START = 0;
  localparam int ACT_HOP   = 1;
  localparam int N_ACT     = 2;
endpackage

// File: rtl/sync_regs.sv
module sync_regs
  import chan_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CFG_W-1:0]  glb_cfg,
  output logic [N_ACT-1:0]  soft_trig,
  output logic [N_ACT-1:0]  pin_en,
  output logic [N_ACT-1:0]  pin_sel,
  output logic              first_only,
  output logic              rearm,
  output logic [DATA_W-1:0] start_hold,
  output logic [DATA_W-1:0] hop_hold,
  output logic [FREQ_W-1:0] stg_freq
);
  logic [CFG_W-1:0]  cfg_q, cfg_nx;
  logic              own_q, own_nx;
  logic [N_ACT-1:0]  sel_q, sel_nx;
  logic [DATA_W-1:0] sth_q, sth_nx, hph_q, hph_nx, flo_q, flo_nx, fhi_q, fhi_nx;
  logic [CFG_W-1:0]  cfg_eff;

  always_comb begin
    cfg_nx = cfg_q;
    own_nx = own_q;
    sel_nx = sel_q;
    sth_nx = sth_q;
    hph_nx = hph_q;
    flo_nx = flo_q;
    fhi_nx = fhi_q;
    if (wr_en) begin
      case (wr_addr)
        A_PCFG: begin cfg_nx = wr_data[CFG_W-1:0]; own_nx = 1'b1; end
        A_PSEL: sel_nx = wr_data[N_ACT-1:0];
        A_STHO: sth_nx = wr_data;
        A_HPHO: hph_nx = wr_data;
        A_FLO:  flo_nx = wr_data;
        A_FHI:  fhi_nx = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      own_q <= 1'b0;
      sel_q <= '0;
      sth_q <= '0;
      hph_q <= '0;
      flo_q <= '0;
      fhi_q <= '0;
    end else begin
      cfg_q <= cfg_nx;
      own_q <= own_nx;
      sel_q <= sel_nx;
      sth_q <= sth_nx;
      hph_q <= hph_nx;
      flo_q <= flo_nx;
      fhi_q <= fhi_nx;
    end
  end

  always_comb begin
    cfg_eff    = own_q ? cfg_q : glb_cfg;
    pin_en     = cfg_eff[N_ACT-1:0];
    first_only = cfg_eff[N_ACT];
    pin_sel    = sel_q;
    rearm      = wr_en && (wr_addr == A_PCFG);
    soft_trig  = (wr_en && (wr_addr == A_TRIG)) ? wr_data[N_ACT-1:0] : '0;
    start_hold = sth_q;
    hop_hold   = hph_q;
    stg_freq   = {fhi_q, flo_q};
  end
endmodule

// File: rtl/pin_sync_front.sv
module pin_sync_front
  import chan_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [N_ACT-1:0] en,
  input  logic [N_ACT-1:0] sel,
  input  logic             first_only,
  input  logic             rearm,
  output logic [N_ACT-1:0] trig
);
  logic s1_q, s2_q, s3_q;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;

  for (genvar g = 0; g < N_ACT; g++) begin : g_act
    logic accept;
    logic done_q, done_nx;

    always_comb begin
      accept  = rise & en[g] & sel[g];
      trig[g] = accept & ~(first_only & done_q);
      done_nx = done_q;
      if (rearm)       done_nx = 1'b0;
      else if (accept) done_nx = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= done_nx;
    end
  end
endmodule

// File: rtl/holdoff_counter.sv
module holdoff_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig,
  input  logic [W-1:0] load_val,
  output logic         expire,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = count;
    if (trig && (load_val != '0)) cnt_nx = load_val;
    else if (count != '0)         cnt_nx = count - 1'b1;
    expire = (count == W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_nx;
  end
endmodule

// File: rtl/chan_sync_ctrl.sv
module chan_sync_ctrl
  import chan_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sync_pin,
  input  logic [CFG_W-1:0]  glb_pin_cfg,
  output logic              start_pulse,
  output logic              sleep,
  output logic [FREQ_W-1:0] freq_word,
  output logic              freq_upd
);
  logic [N_ACT-1:0]  soft_trig, pin_en, pin_sel, pin_trig, any_trig;
  logic              first_only, rearm;
  logic [DATA_W-1:0] start_hold, hop_hold, start_cnt, hop_cnt;
  logic [FREQ_W-1:0] stg_freq;
  logic              start_exp, hop_exp;
  logic              sleep_nx, start_nx, upd_nx;
  logic [FREQ_W-1:0] freq_nx;

  sync_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .glb_cfg(glb_pin_cfg), .soft_trig(soft_trig), .pin_en(pin_en), .pin_sel(pin_sel),
    .first_only(first_only), .rearm(rearm), .start_hold(start_hold),
    .hop_hold(hop_hold), .stg_freq(stg_freq)
  );

  pin_sync_front u_pin (
    .clk(clk), .rst_n(rst_n), .pin(sync_pin), .en(pin_en), .sel(pin_sel),
    .first_only(first_only), .rearm(rearm), .trig(pin_trig)
  );

  assign any_trig = soft_trig | pin_trig;

  holdoff_counter #(.W(DATA_W)) u_start_cnt (
    .clk(clk), .rst_n(rst_n), .trig(any_trig[ACT_START]), .load_val(start_hold),
    .expire(start_exp), .count(start_cnt)
  );

  holdoff_counter #(.W(DATA_W)) u_hop_cnt (
    .clk(clk), .rst_n(rst_n), .trig(any_trig[ACT_HOP]), .load_val(hop_hold),
    .expire(hop_exp), .count(hop_cnt)
  );

  always_comb begin
    start_nx = start_exp;
    sleep_nx = start_exp ? 1'b0 : sleep;
    upd_nx   = hop_exp;
    freq_nx  = hop_exp ? stg_freq : freq_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      sleep       <= 1'b1;
      freq_upd    <= 1'b0;
      freq_word   <= '0;
    end else begin
      start_pulse <= start_nx;
      sleep       <= sleep_nx;
      freq_upd    <= upd_nx;
      freq_word   <= freq_nx;
    end
  end
endmodule

// File: rtl/chan_sync_ctrl_chk.sv
module chan_sync_ctrl_chk
  import chan_sync_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_pulse,
  input logic              sleep,
  input logic              freq_upd,
  input logic [FREQ_W-1:0] freq_word,
  input logic [FREQ_W-1:0] stg_freq,
  input logic [DATA_W-1:0] start_cnt
);
  assert_start_at_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(start_cnt) == DATA_W'(1));

  assert_wake_with_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !sleep);

  assert_stay_awake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> !sleep);

  assert_upd_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    freq_upd |-> freq_word == $past(stg_freq));

  assert_freq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_upd |-> $stable(freq_word));
endmodule

bind chan_sync_ctrl chan_sync_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .sleep(sleep),
  .freq_upd(freq_upd), .freq_word(freq_word), .stg_freq(stg_freq),
  .start_cnt(start_cnt)
);

// File: tb/chan_sync_ctrl_test.sv
module chan_sync_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        sync_pin;
  logic [2:0]  glb_pin_cfg;
  logic        start_pulse, sleep, freq_upd;
  logic [31:0] freq_word;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  chan_sync_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_pin(sync_pin), .glb_pin_cfg(glb_pin_cfg), .start_pulse(start_pulse),
    .sleep(sleep), .freq_word(freq_word), .freq_upd(freq_upd)
  );

  // {kind (0 start, 1 hop), hold-off, low half, high half}
  localparam logic [48:0] VECS [0:5] = '{
    {1'b0, 16'd3,  16'h0000, 16'h0000},
    {1'b1, 16'd1,  16'h1234, 16'hABCD},
    {1'b0, 16'd1,  16'h0000, 16'h0000},
    {1'b1, 16'd6,  16'hF00F, 16'h0FF0},
    {1'b0, 16'd13, 16'h0000, 16'h0000},
    {1'b1, 16'd2,  16'h8001, 16'h7FFE}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pin_pulse();
    @(negedge clk);
    sync_pin = 1'b1;
    @(negedge clk);
    sync_pin = 1'b0;
  endtask

  // returns the edge index (1 = first edge after the trigger edge) of the first pulse, 0 if none
  task automatic measure(input bit hop, input int lim, output int k);
    k = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk); #1;
      if (k == 0 && (hop ? freq_upd : start_pulse)) k = i;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    logic [31:0] fw;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    sync_pin = 1'b0; glb_pin_cfg = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check(sleep == 1'b1, "R1 sleep", 32'(sleep), 1);
    check(start_pulse == 1'b0, "R1 start_pulse", 32'(start_pulse), 0);
    check(freq_upd == 1'b0, "R1 freq_upd", 32'(freq_upd), 0);
    check(freq_word == 32'h0, "R1 freq_word", freq_word, 0);

    // R2 / R3 table walk
    for (int v = 0; v < 6; v++) begin
      logic        kind;
      logic [15:0] hold, lo, hi;
      {kind, hold, lo, hi} = VECS[v];
      if (!kind) begin
        wr(3'd3, hold);
        wr(3'd0, 16'h0001);
        measure(1'b0, int'(hold) + 4, k);
        check(k == int'(hold), "R2 start latency", 32'(k), 32'(hold));
        check(sleep == 1'b0, "R2 sleep cleared", 32'(sleep), 0);
      end else begin
        wr(3'd4, hold);
        wr(3'd5, lo);
        wr(3'd6, hi);
        wr(3'd0, 16'h0002);
        measure(1'b1, int'(hold) + 4, k);
        check(k == int'(hold), "R3 hop latency", 32'(k), 32'(hold));
        check(freq_word == {hi, lo}, "R3 hop word", freq_word, {hi, lo});
      end
    end

    // R10 staging does not change active word
    fw = freq_word;
    wr(3'd5, 16'h2222);
    wr(3'd6, 16'h3333);
    measure(1'b1, 5, k);
    check(k == 0 && freq_word == fw, "R10 staged only", freq_word, fw);

    // R4 zero hold-off ignores triggers
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h0001);
    measure(1'b0, 12, k);
    check(k == 0, "R4 start zero", 32'(k), 0);
    wr(3'd4, 16'd0);
    wr(3'd0, 16'h0002);
    measure(1'b1, 12, k);
    check(k == 0 && freq_word == fw, "R4 hop zero", freq_word, fw);

    // R5 retrigger reloads
    wr(3'd3, 16'd6);
    wr(3'd0, 16'h0001);
    wr(3'd0, 16'h0001);
    measure(1'b0, 12, k);
    check(k == 6, "R5 reload", 32'(k), 6);

    // pin path, start hold-off 2
    wr(3'd3, 16'd2);
    wr(3'd4, 16'd2);
    @(negedge clk) glb_pin_cfg = 3'b001;
    pin_pulse();
    measure(1'b0, 10, k);
    check(k == 0, "R6 no select", 32'(k), 0);
    wr(3'd2, 16'h0001);
    pin_pulse();
    measure(1'b0, 10, k);
    check(k == 4, "R7 R9 pin via global", 32'(k), 4);
    @(negedge clk) glb_pin_cfg = 3'b000;
    pin_pulse();
    measure(1'b0, 10, k);
    check(k == 0, "R9 global disabled", 32'(k), 0);
    wr(3'd1, 16'h0002);
    pin_pulse();
    measure(1'b0, 10, k);
    check(k == 0, "R6 no start enable", 32'(k), 0);
    wr(3'd1, 16'h0001);
    pin_pulse();
    measure(1'b0, 10, k);
    check(k == 4, "R9 own config", 32'(k), 4);

    // R8 first-pulse-only
    wr(3'd2, 16'h0003);
    wr(3'd1, 16'h0007);
    pin_pulse();
    measure(1'b0, 10, k);
    check(k == 4, "R8 first pulse", 32'(k), 4);
    pin_pulse();
    measure(1'b0, 10, k);
    check(k == 0, "R8 second blocked", 32'(k), 0);
    wr(3'd1, 16'h0007);
    pin_pulse();
    measure(1'b0, 10, k);
    check(k == 4, "R8 rearmed", 32'(k), 4);

    // R7 pin hop
    wr(3'd1, 16'h0003);
    wr(3'd5, 16'h5555);
    wr(3'd6, 16'h6666);
    pin_pulse();
    measure(1'b1, 10, k);
    check(k == 4, "R7 pin hop latency", 32'(k), 4);
    check(freq_word == 32'h66665555, "R7 pin hop word", freq_word, 32'h66665555);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule